// File: doc/BRIEF.md
# Machine Cycle Timing Sequencer

This block produces the machine-cycle timing of a small byte-wide processor core. Two active-low control pins, a clear pin and a wait pin, are decoded into four operating modes. The block counts clock pulses inside each machine cycle and raises two timing strobes at fixed pulse positions. At the end of every cycle it picks the next machine state: fetch, execute, DMA or interrupt. Each rising edge of `clk` counts as one timing pulse.

The instruction decoder tells the sequencer whether an instruction needs a second execute cycle. The surrounding core supplies the DMA-in and DMA-out requests and an interrupt flag that is already qualified by the interrupt enable. The sequencer does nothing with instruction meaning. It only decides how many pulses a cycle lasts, which state comes next, and when the strobes fire.

Leaving reset starts an initialization cycle that is one pulse longer than a normal cycle. A pause mode freezes all timing at the clock edge where it is first seen. A load mode keeps the core in an idle execute state, so that DMA traffic can fill memory without starting any instructions.

Top module: `mcycle_seq`

## Requirements
- R1: The mode output equals {clear_n, wait_n}. Code 0 is LOAD (both low), 1 is RESET (clear_n low, wait_n high), 2 is PAUSE (clear_n high, wait_n low) and 3 is RUN (both high).
- R2: In RUN or LOAD the pulse count advances by one on every clock edge. A normal cycle runs through counts 0 to 7. The initialization cycle runs through counts 0 to 8, and count 8 appears in no other cycle.
- R3: While RESET is selected, or `rst_n` is low, the next edge puts the state at execute (code 1), the pulse count at 0 and the initialization flag at 1. TPA and TPB stay low for as long as RESET is selected.
- R4: The cycle after RESET is the initialization cycle. It stays in execute, lasts 9 edges, and ignores the DMA and interrupt inputs. The initialization flag falls at its final edge.
- R5: After the initialization cycle the state becomes DMA (code 2) if either DMA request is high, and otherwise fetch (code 0). It never becomes interrupt (code 3).
- R6: In RUN, a fetch cycle (code 0) is always followed by an execute cycle. At the end of the first execute cycle, a high `need_exec2` starts a second execute cycle.
- R7: In RUN, at the end of the last execute cycle or of a DMA cycle, the next state is chosen in priority order: DMA if any DMA request is high, then interrupt if `int_pending` is high, otherwise fetch. An interrupt cycle is always followed by fetch, and no request is examined at its end.
- R8: PAUSE holds the state, pulse count, initialization flag and strobes unchanged on every edge. Returning to RUN continues from the same count on the next edge.
- R9: In LOAD, every cycle end without a DMA request leads to execute (code 1), including the end of a DMA cycle. A DMA request leads to DMA. `int_pending` and `need_exec2` are ignored.
- R10: Outside RESET, TPA is high exactly while the pulse count is 1 and TPB is high exactly while it is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; one rising edge per pulse |
| rst_n | input | 1 | Synchronous active-low reset, same effect as RESET mode |
| clear_n | input | 1 | Active-low clear control pin |
| wait_n | input | 1 | Active-low wait control pin |
| dma_in_req | input | 1 | DMA-in request |
| dma_out_req | input | 1 | DMA-out request |
| int_pending | input | 1 | Interrupt request already qualified by enable |
| need_exec2 | input | 1 | Decoder flag: instruction needs a second execute cycle |
| mode | output | 2 | Decoded control mode |
| mstate | output | 2 | Machine state: 0 fetch, 1 execute, 2 DMA, 3 interrupt |
| pulse | output | 4 | Pulse count within the current cycle |
| tpa | output | 1 | First timing strobe |
| tpb | output | 1 | Second timing strobe |
| init_cycle | output | 1 | High through RESET and the initialization cycle |

## Verification
Directed sequences come first. One holds DMA and interrupt high while reset is released, which shows whether the 9-pulse initialization cycle masks both requests and then yields DMA rather than interrupt. Another drops DMA while the interrupt is still high, which separates the DMA-over-interrupt priority from the interrupt-to-fetch return. A pause placed in the middle of a cycle shows whether the freeze and the resume land on the exact count. A long LOAD stretch with interrupt and second-execute requests held high shows whether the idle state ignores them and whether the state returns to idle after a DMA cycle. Random stretches of all four modes with sparse, overlapping requests then compare every output against a bench model on every cycle.

// File: rtl/mcycle_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the machine cycle sequencer.
// Assumes mode codes are the raw {clear_n, wait_n} pin pair.
package mcycle_seq_pkg;

    typedef enum logic [1:0] {
        MODE_LOAD  = 2'b00,
        MODE_RESET = 2'b01,
        MODE_PAUSE = 2'b10,
        MODE_RUN   = 2'b11
    } ctl_mode_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'b00,
        ST_EXEC  = 2'b01,
        ST_DMA   = 2'b10,
        ST_INTR  = 2'b11
    } mstate_e;

endpackage

// File: rtl/mcycle_mode_dec.sv
`timescale 1ns/1ps
// Module: mcycle_mode_dec
// Decodes the two active-low control pins into the operating mode and
// the qualifiers used by the rest of the sequencer.
// Assumes the pins are already synchronous to clk.
module mcycle_mode_dec
    import mcycle_seq_pkg::*;
(
    input  logic      clear_n,
    input  logic      wait_n,
    output ctl_mode_e mode,
    output logic      advance,
    output logic      hold_reset,
    output logic      load_idle
);

    // Purpose: map pin pair to mode and derive the per-mode qualifiers.
    always_comb begin
        unique case ({clear_n, wait_n})
            2'b00:   mode = MODE_LOAD;
            2'b01:   mode = MODE_RESET;
            2'b10:   mode = MODE_PAUSE;
            default: mode = MODE_RUN;
        endcase
        advance    = (mode == MODE_RUN) || (mode == MODE_LOAD);
        hold_reset = (mode == MODE_RESET);
        load_idle  = (mode == MODE_LOAD);
    end

endmodule

// File: rtl/mcycle_pulse_ctr.sv
`timescale 1ns/1ps
// Module: mcycle_pulse_ctr
// Counts pulses within a machine cycle. The cycle is NORM_PULSES long, or
// INIT_PULSES long while long_cycle is high. Flags the last pulse.
// Assumes clr and adv are never high together.
module mcycle_pulse_ctr #(
    parameter int NORM_PULSES = 8,
    parameter int INIT_PULSES = 9,
    localparam int CNT_W = $clog2(INIT_PULSES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic             long_cycle,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    localparam logic [CNT_W-1:0] NORM_END = CNT_W'(NORM_PULSES - 1);
    localparam logic [CNT_W-1:0] INIT_END = CNT_W'(INIT_PULSES - 1);
    localparam logic [CNT_W-1:0] INIT_TOP = CNT_W'(INIT_PULSES);
    localparam logic [CNT_W-1:0] NORM_TOP = CNT_W'(NORM_PULSES);

    logic [CNT_W-1:0] end_cnt;

    // Purpose: select the terminal count for the current cycle kind.
    always_comb begin
        end_cnt = long_cycle ? INIT_END : NORM_END;
        last    = adv && (cnt == end_cnt);
    end

    // Purpose: advance, wrap or clear the pulse count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (adv) begin
            if (last) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: count never reaches the long-cycle length
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < INIT_TOP);

    // R2: the extra pulse only exists in the long cycle
    a_r2_extra_only_init: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= NORM_TOP) |-> long_cycle);

endmodule

// File: rtl/mcycle_state_sel.sv
`timescale 1ns/1ps
// Module: mcycle_state_sel
// Holds the machine state, the initialization flag and the second-execute
// marker, and chooses the next state at each cycle end.
// Assumes cyc_end is only high while the sequencer advances.
module mcycle_state_sel
    import mcycle_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  logic    cyc_end,
    input  logic    load_idle,
    input  logic    dma_any,
    input  logic    int_pend,
    input  logic    need2,
    output mstate_e state_q,
    output logic    init_q
);

    logic    second_q;
    mstate_e pick;
    mstate_e nxt;
    logic    nxt_second;
    logic    nxt_init;

    // Purpose: priority choice at the end of an instruction or DMA cycle.
    always_comb begin
        if (dma_any) begin
            pick = ST_DMA;
        end else if (load_idle) begin
            pick = ST_EXEC;
        end else if (int_pend) begin
            pick = ST_INTR;
        end else begin
            pick = ST_FETCH;
        end
    end

    // Purpose: next-state, init and second-execute decisions.
    always_comb begin
        nxt        = state_q;
        nxt_second = second_q;
        nxt_init   = init_q;
        if (cyc_end) begin
            nxt_second = 1'b0;
            if (init_q) begin
                nxt_init = 1'b0;
                nxt      = dma_any ? ST_DMA : (load_idle ? ST_EXEC : ST_FETCH);
            end else begin
                unique case (state_q)
                    ST_FETCH: nxt = ST_EXEC;
                    ST_EXEC: begin
                        if (!second_q && need2 && !load_idle) begin
                            nxt        = ST_EXEC;
                            nxt_second = 1'b1;
                        end else begin
                            nxt = pick;
                        end
                    end
                    ST_DMA:  nxt = pick;
                    default: nxt = load_idle ? ST_EXEC : ST_FETCH;
                endcase
            end
        end
    end

    // Purpose: state registers with reset-mode override.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q  <= ST_EXEC;
            init_q   <= 1'b1;
            second_q <= 1'b0;
        end else begin
            state_q  <= nxt;
            init_q   <= nxt_init;
            second_q <= nxt_second;
        end
    end

    // R3: reset mode parks the sequencer in execute with init pending
    a_r3_reset_exec: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == ST_EXEC) && init_q);

    // R5: leaving the init cycle never enters the interrupt state
    a_r5_no_intr_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_q) |-> (state_q != ST_INTR));

    // R6: a fetch cycle is always followed by execute
    a_r6_fetch_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && !init_q && state_q == ST_FETCH && !clr) |=> (state_q == ST_EXEC));

    // R8: without clear and without a cycle end the state holds
    a_r8_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_end && !clr) |=> $stable(state_q) && $stable(init_q));

    // R9: load mode never starts a fetch or interrupt cycle
    a_r9_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && load_idle) |=> (state_q == ST_EXEC) || (state_q == ST_DMA));

endmodule

// File: rtl/mcycle_strobe.sv
`timescale 1ns/1ps
// Module: mcycle_strobe
// Decodes the two timing strobes from the pulse count, gated off in reset.
// Assumes the count is held frozen by the counter during pause.
module mcycle_strobe #(
    parameter int CNT_W  = 4,
    parameter int TPA_AT = 1,
    parameter int TPB_AT = 6
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             hold_reset,
    output logic             tpa,
    output logic             tpb
);

    localparam logic [CNT_W-1:0] A_POS = CNT_W'(TPA_AT);
    localparam logic [CNT_W-1:0] B_POS = CNT_W'(TPB_AT);

    // Purpose: position decode of both strobes with reset gating.
    always_comb begin
        tpa = !hold_reset && (cnt == A_POS);
        tpb = !hold_reset && (cnt == B_POS);
    end

endmodule

// File: rtl/mcycle_seq.sv
`timescale 1ns/1ps
// Module: mcycle_seq (top)
// Machine cycle timing sequencer: mode decode, pulse counter, state choice
// and strobe decode. One rising clk edge is one timing pulse.
// Assumes all inputs are synchronous to clk.
module mcycle_seq
    import mcycle_seq_pkg::*;
#(
    parameter int NORM_PULSES = 8,
    parameter int INIT_PULSES = 9,
    parameter int TPA_AT      = 1,
    parameter int TPB_AT      = 6,
    localparam int CNT_W      = $clog2(INIT_PULSES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_n,
    input  logic             wait_n,
    input  logic             dma_in_req,
    input  logic             dma_out_req,
    input  logic             int_pending,
    input  logic             need_exec2,
    output logic [1:0]       mode,
    output logic [1:0]       mstate,
    output logic [CNT_W-1:0] pulse,
    output logic             tpa,
    output logic             tpb,
    output logic             init_cycle
);

    ctl_mode_e mode_e;
    mstate_e   state_e;
    logic      advance;
    logic      hold_reset;
    logic      load_idle;
    logic      cyc_last;
    logic      init_q;

    mcycle_mode_dec u_mode (
        .clear_n    (clear_n),
        .wait_n     (wait_n),
        .mode       (mode_e),
        .advance    (advance),
        .hold_reset (hold_reset),
        .load_idle  (load_idle)
    );

    mcycle_pulse_ctr #(
        .NORM_PULSES (NORM_PULSES),
        .INIT_PULSES (INIT_PULSES)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (hold_reset),
        .adv        (advance),
        .long_cycle (init_q),
        .cnt        (pulse),
        .last       (cyc_last)
    );

    mcycle_state_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (hold_reset),
        .cyc_end   (cyc_last),
        .load_idle (load_idle),
        .dma_any   (dma_in_req || dma_out_req),
        .int_pend  (int_pending),
        .need2     (need_exec2),
        .state_q   (state_e),
        .init_q    (init_q)
    );

    mcycle_strobe #(
        .CNT_W  (CNT_W),
        .TPA_AT (TPA_AT),
        .TPB_AT (TPB_AT)
    ) u_strb (
        .cnt        (pulse),
        .hold_reset (hold_reset),
        .tpa        (tpa),
        .tpb        (tpb)
    );

    // Purpose: present internal enums on plain output ports.
    always_comb begin
        mode       = mode_e;
        mstate     = state_e;
        init_cycle = init_q;
    end

    // R3: strobes are silent whenever reset mode is selected
    a_r3_strobes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_RESET) |-> !tpa && !tpb);

    // R8: strobes keep their value across consecutive pause edges
    a_r8_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_PAUSE && $past(mode_e) == MODE_PAUSE && $past(rst_n))
            |-> $stable(tpa) && $stable(tpb));

    // R10: the two strobes are never high together
    a_r10_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(tpa && tpb));

endmodule

// File: tb/mcycle_seq_test.sv
`timescale 1ns/1ps
module mcycle_seq_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       b_clear, b_wait, b_dmi, b_dmo, b_int, b_need;
    logic [1:0] mode, mstate;
    logic [3:0] pulse;
    logic       tpa, tpb, init_cycle;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;

    // bench model of the requirements
    int m_state, m_pulse, m_init, m_second;

    always #4 clk = ~clk;

    mcycle_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_n     (b_clear),
        .wait_n      (b_wait),
        .dma_in_req  (b_dmi),
        .dma_out_req (b_dmo),
        .int_pending (b_int),
        .need_exec2  (b_need),
        .mode        (mode),
        .mstate      (mstate),
        .pulse       (pulse),
        .tpa         (tpa),
        .tpb         (tpb),
        .init_cycle  (init_cycle)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mode_code();
        return {30'd0, b_clear, b_wait};
    endfunction

    // priority choice of R7 / R9 at the end of an instruction or DMA cycle
    function automatic int pick_next(input bit dma, input bit ld, input bit irq);
        if (dma) return 2;
        if (ld) return 1;
        if (irq) return 3;
        return 0;
    endfunction

    // model step per clock edge
    always @(posedge clk) begin
        int md, len;
        bit dma, ld;
        md  = mode_code();
        dma = b_dmi || b_dmo;
        ld  = (md == 0);
        if (!rst_n || md == 1) begin
            m_state <= 1; m_pulse <= 0; m_init <= 1; m_second <= 0;
        end else if (md != 2) begin
            len = (m_init != 0) ? 9 : 8;
            if (m_pulse != len - 1) begin
                m_pulse <= m_pulse + 1;
            end else begin
                m_pulse  <= 0;
                m_second <= 0;
                if (m_init != 0) begin
                    m_init  <= 0;
                    m_state <= dma ? 2 : (ld ? 1 : 0);
                end else if (m_state == 0) begin
                    m_state <= 1;
                end else if (m_state == 1) begin
                    if (m_second == 0 && b_need && !ld) begin
                        m_state <= 1; m_second <= 1;
                    end else begin
                        m_state <= pick_next(dma, ld, b_int);
                    end
                end else if (m_state == 2) begin
                    m_state <= pick_next(dma, ld, b_int);
                end else begin
                    m_state <= ld ? 1 : 0;
                end
            end
        end
    end

    // per-cycle comparison, sampled at the falling edge
    always @(negedge clk) begin
        if (chk_en) begin
            chk("R1 mode", mode, mode_code());
            chk("R4 R5 R6 R7 R9 state", mstate, m_state);
            chk("R2 R8 pulse", pulse, m_pulse);
            chk("R3 R4 init flag", init_cycle, m_init);
            chk("R3 R10 tpa", tpa, (m_pulse == 1 && mode_code() != 1) ? 1 : 0);
            chk("R3 R10 tpb", tpb, (m_pulse == 6 && mode_code() != 1) ? 1 : 0);
        end
    end

    task automatic set_mode(input int md);
        {b_clear, b_wait} = md[1:0];
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1..all actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, maxp, seg, r;
        int unsigned seed_v;
        seed_v = $urandom(32'd4242);
        rst_n = 1'b0;
        set_mode(1);
        b_dmi = 0; b_dmo = 0; b_int = 0; b_need = 0;
        repeat (4) @(negedge clk);
        chk_en = 1'b1;
        // R3: reset state
        chk("R3 reset state", mstate, 1);
        chk("R3 reset pulse", pulse, 0);
        chk("R3 reset tpa", tpa, 0);
        #1;
        rst_n = 1'b1;
        tick();

        // R4 R5: init cycle with DMA and interrupt held high
        b_dmi = 1; b_int = 1; set_mode(3);
        n = 0; maxp = 0;
        do begin
            @(negedge clk);
            n++;
            if (pulse > maxp) maxp = pulse;
        end while (init_cycle && n < 40);
        chk("R4 init cycle edges", n, 9);
        chk("R2 init cycle top count", maxp, 8);
        chk("R5 state after init with DMA", mstate, 2);
        #1;

        // R7: DMA drops while interrupt stays high -> interrupt, then fetch
        b_dmi = 0;
        n = 0;
        do begin @(negedge clk); n++; end while (mstate == 2 && n < 40);
        chk("R7 DMA gone, interrupt next", mstate, 3);
        #1;
        n = 0;
        do begin @(negedge clk); n++; end while (mstate == 3 && n < 40);
        chk("R7 interrupt followed by fetch", mstate, 0);
        #1;
        b_int = 0;

        // R8: pause mid-cycle
        n = 0;
        do begin @(negedge clk); n++; end while (pulse != 3 && n < 40);
        #1;
        set_mode(2);
        repeat (6) @(negedge clk);
        chk("R8 pause holds pulse", pulse, 3);
        #1;
        set_mode(3);
        @(negedge clk);
        chk("R8 resume continues count", pulse, 4);
        #1;

        // R9: load mode stays idle despite interrupt and second-execute flags
        set_mode(1);
        tick(); tick();
        set_mode(0);
        b_int = 1; b_need = 1;
        repeat (41) @(negedge clk);
        chk("R9 load idle state", mstate, 1);
        chk("R9 load idle no strobe in count 0", pulse, 0);
        #1;
        b_dmi = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (mstate != 2 && n < 40);
        chk("R9 load DMA cycle", mstate, 2);
        #1;
        b_dmi = 0;
        n = 0;
        do begin @(negedge clk); n++; end while (mstate == 2 && n < 40);
        chk("R9 load returns to idle after DMA", mstate, 1);
        #1;
        b_int = 0; b_need = 0;

        // random mix of modes and requests
        seg = 0;
        for (int i = 0; i < 4000; i++) begin
            tick();
            if (seg == 0) begin
                r = $urandom % 100;
                if (r < 65) begin
                    set_mode(3); seg = 20 + $urandom % 60;
                end else if (r < 78) begin
                    set_mode(2); seg = 1 + $urandom % 8;
                end else if (r < 86) begin
                    set_mode(1); seg = 1 + $urandom % 4;
                end else begin
                    set_mode(0); seg = 20 + $urandom % 50;
                end
            end
            seg--;
            b_dmi  = ($urandom % 100) < 12;
            b_dmo  = ($urandom % 100) < 6;
            b_int  = ($urandom % 100) < 35;
            b_need = ($urandom % 100) < 50;
        end
        tick();
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule